// File: doc/BRIEF.md
# Sequential Stream Cache Prefetcher

This block sits beside a level-one data cache and listens to its miss traffic. Each miss carries a byte address and a flag that marks it as a store. Load misses train a two-level detector. A twelve-entry candidate filter remembers recent one-off misses. A table of up to eight confirmed streams runs ahead of the demand pattern. The block detects runs of accesses to adjacent 128-byte lines, climbing or falling, and emits line-aligned prefetch addresses on a valid/ready port.

On its first sight of a line, the block guesses which way the run is heading from where the miss falls inside that line. It then parks that guess in the filter as the line it expects next. A later load miss to that expected line confirms the run. The entry is then promoted into the stream table, and two lines ahead are requested. After that, each load miss that hits a stream's expected line moves the stream on by one line and requests one more line, so the lookahead stays two lines deep.

Each accepted load miss is classified in a single cycle into one of four actions. IDLE means no load was taken. ADVANCE means a stream matched. PROMOTE means a filter entry matched. TRAIN means nothing matched and a new filter entry is written. Requests wait in a small queue until the consumer takes them.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset, `pf_valid` is low and `miss_ready` is high.
- R2: The line number is the address shifted right by 7. For a new miss, the guessed direction is ascending when the offset within the line is 0 to 95, and descending when it is 96 to 127. The filter then expects line+1 or line-1 respectively.
- R3: A load miss on a filter entry's expected line L promotes the entry to a stream in that entry's direction d. From the next cycle on, the block requests L+d and then L+2d, in that order.
- R4: A load miss on a stream's expected line L moves that stream's expectation to L+d and requests exactly one line, L+2d.
- R5: A miss with `miss_is_store` high changes no filter entry and no stream, and requests nothing.
- R6: When a load miss matches both a stream and a filter entry, only the stream is updated, so a single request results.
- R7: The filter holds 12 candidates. When it is full, a new candidate overwrites the oldest one, in first-in first-out order.
- R8: The stream table holds 8 streams. Promotion into a full table replaces the least recently advanced or created stream.
- R9: `pf_addr` is line-aligned, with its low 7 bits zero. Requests leave in the order they were made. While `pf_valid` is high and `pf_ready` is low, `pf_addr` stays stable and no request is lost.
- R10: `miss_ready` is low whenever the request queue has fewer than two free slots. A load miss is taken only on a cycle with `miss_valid` and `miss_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | A cache miss is presented |
| miss_ready | output | 1 | Room exists to take a load miss |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_is_store | input | 1 | Miss came from a store |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Consumer takes the offered request |
| pf_addr | output | ADDR_W | Line-aligned prefetch byte address |

## Verification
A wrong internal state shows up as missing, extra or misordered prefetch addresses. Every table update is visible one cycle after the miss that caused it. A bad direction guess or a lost filter candidate turns a promotion that should happen into silence, so the two expected requests never arrive. A stream that advanced when it should not have, or a stream evicted out of least-recent order, shows at the next load miss on its expected line: that miss then yields two requests, or none, instead of one. A corrupted queue pointer shows as a changed or repeated address while the consumer stalls.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int OFF_W = 7;
    localparam int LINE_BYTES = 1 << OFF_W;
    localparam int GUESS_LIM = (LINE_BYTES * 3) / 4;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_ADVANCE,
        ACT_PROMOTE,
        ACT_TRAIN
    } act_e;
endpackage

// File: rtl/sp_filter.sv
module sp_filter #(
    parameter int LINE_W = 25,
    parameter int N = 12,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              hit_desc,
    input  logic              clear_en,
    input  logic              alloc_en,
    input  logic              alloc_desc,
    input  logic [LINE_W-1:0] alloc_exp
);
    logic [N-1:0]      valid_q;
    logic [N-1:0]      desc_q;
    logic [LINE_W-1:0] exp_q [N];
    logic [IDX_W-1:0]  wr_q;

    always_comb begin
        hit = 1'b0;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid_q[i] && exp_q[i] == look_line) begin
                hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        hit_desc = desc_q[hit_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            desc_q  <= '0;
            wr_q    <= '0;
            for (int i = 0; i < N; i++) exp_q[i] <= '0;
        end else begin
            if (clear_en) valid_q[hit_idx] <= 1'b0;
            if (alloc_en) begin
                valid_q[wr_q] <= 1'b1;
                desc_q[wr_q]  <= alloc_desc;
                exp_q[wr_q]   <= alloc_exp;
                wr_q <= (wr_q == IDX_W'(N - 1)) ? '0 : wr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_stream_table.sv
module sp_stream_table #(
    parameter int LINE_W = 25,
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line,
    output logic              hit,
    output logic              hit_desc,
    input  logic              adv_en,
    input  logic              alloc_en,
    input  logic              alloc_desc,
    input  logic [LINE_W-1:0] alloc_next
);
    logic [N-1:0]      valid_q;
    logic [N-1:0]      desc_q;
    logic [LINE_W-1:0] next_q [N];
    logic [IDX_W-1:0]  age_q  [N];
    logic [IDX_W-1:0]  hit_idx, victim, tgt;

    always_comb begin
        hit = 1'b0;
        hit_idx = '0;
        victim = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid_q[i] && next_q[i] == look_line) begin
                hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (age_q[i] == IDX_W'(N - 1)) victim = IDX_W'(i);
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_q[i]) victim = IDX_W'(i);
        end
        hit_desc = desc_q[hit_idx];
        tgt = adv_en ? hit_idx : victim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            desc_q  <= '0;
            for (int i = 0; i < N; i++) begin
                next_q[i] <= '0;
                age_q[i]  <= IDX_W'(i);
            end
        end else if (adv_en || alloc_en) begin
            for (int i = 0; i < N; i++) begin
                if (age_q[i] < age_q[tgt]) age_q[i] <= age_q[i] + 1'b1;
            end
            age_q[tgt] <= '0;
            if (adv_en) begin
                next_q[tgt] <= desc_q[tgt] ? look_line - 1'b1 : look_line + 1'b1;
            end else begin
                valid_q[tgt] <= 1'b1;
                desc_q[tgt]  <= alloc_desc;
                next_q[tgt]  <= alloc_next;
            end
        end
    end
endmodule

// File: rtl/sp_req_queue.sv
module sp_req_queue #(
    parameter int W = 25,
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  push_a,
    input  logic [W-1:0]  push_b,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            count <= '0;
        end else begin
            if (pop) rd_q <= bump(rd_q);
            if (push_n == 2'd1) wr_q <= bump(wr_q);
            else if (push_n == 2'd2) wr_q <= bump(bump(wr_q));
            count <= count + CW'(push_n) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wr_q] <= push_a;
        if (push_n == 2'd2) mem[bump(wr_q)] <= push_b;
    end

    assign head = mem[rd_q];
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
    import sp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_STREAMS = 8,
    parameter int N_FILTER = 12,
    parameter int Q_DEPTH = 4,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int QCW = $clog2(Q_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              miss_is_store,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    logic [LINE_W-1:0] line, push_a, push_b, f_alloc_exp, s_alloc_next, q_head;
    logic [OFF_W-1:0]  offset;
    logic              take, guess_desc;
    logic              s_hit, s_desc, f_hit, f_desc;
    logic              s_adv, s_alloc, f_clear, f_alloc;
    logic [1:0]        push_n;
    logic [QCW-1:0]    q_count;
    act_e              act;

    assign line   = miss_addr[ADDR_W-1:OFF_W];
    assign offset = miss_addr[OFF_W-1:0];
    assign take   = miss_valid && miss_ready && !miss_is_store;
    assign guess_desc = offset >= OFF_W'(GUESS_LIM);

    always_comb begin
        act = ACT_IDLE;
        if (take) begin
            if (s_hit)      act = ACT_ADVANCE;
            else if (f_hit) act = ACT_PROMOTE;
            else            act = ACT_TRAIN;
        end
    end

    always_comb begin
        s_adv = 1'b0;
        s_alloc = 1'b0;
        f_clear = 1'b0;
        f_alloc = 1'b0;
        push_n = 2'd0;
        push_a = line;
        push_b = line;
        s_alloc_next = line;
        f_alloc_exp = guess_desc ? line - 1'b1 : line + 1'b1;
        unique case (act)
            ACT_IDLE: ;
            ACT_ADVANCE: begin
                s_adv  = 1'b1;
                push_n = 2'd1;
                push_a = s_desc ? line - 2'd2 : line + 2'd2;
            end
            ACT_PROMOTE: begin
                f_clear = 1'b1;
                s_alloc = 1'b1;
                s_alloc_next = f_desc ? line - 1'b1 : line + 1'b1;
                push_n = 2'd2;
                push_a = s_alloc_next;
                push_b = f_desc ? line - 2'd2 : line + 2'd2;
            end
            ACT_TRAIN: f_alloc = 1'b1;
        endcase
    end

    sp_stream_table #(.LINE_W(LINE_W), .N(N_STREAMS)) u_streams (
        .clk(clk), .rst_n(rst_n), .look_line(line),
        .hit(s_hit), .hit_desc(s_desc),
        .adv_en(s_adv), .alloc_en(s_alloc),
        .alloc_desc(f_desc), .alloc_next(s_alloc_next)
    );

    sp_filter #(.LINE_W(LINE_W), .N(N_FILTER)) u_filter (
        .clk(clk), .rst_n(rst_n), .look_line(line),
        .hit(f_hit), .hit_idx(), .hit_desc(f_desc),
        .clear_en(f_clear), .alloc_en(f_alloc),
        .alloc_desc(guess_desc), .alloc_exp(f_alloc_exp)
    );

    sp_req_queue #(.W(LINE_W), .DEPTH(Q_DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push_n(push_n),
        .push_a(push_a), .push_b(push_b),
        .pop(pf_valid && pf_ready), .head(q_head), .count(q_count)
    );

    assign pf_valid   = q_count != '0;
    assign pf_addr    = {q_head, OFF_W'(0)};
    assign miss_ready = q_count <= QCW'(Q_DEPTH - 2);
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
    parameter int ADDR_W = 32,
    parameter int Q_DEPTH = 4,
    localparam int QCW = $clog2(Q_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              miss_is_store,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic [QCW-1:0]    q_count
);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

    p_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> pf_addr[6:0] == 7'd0);

    p_store_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_is_store && !pf_valid |=> !pf_valid);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready |=> q_count <= QCW'(Q_DEPTH));

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_ready && !pf_ready |=> !miss_ready);
endmodule

bind stream_prefetcher sp_checker #(.ADDR_W(ADDR_W), .Q_DEPTH(Q_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_is_store(miss_is_store), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr), .q_count(q_count)
);

// File: tb/stream_prefetcher_test.sv
`timescale 1ns/1ps
module stream_prefetcher_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic        miss_is_store = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        pf_ready = 1'b1;
    logic        miss_ready, pf_valid;
    logic [31:0] pf_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    stream_prefetcher uut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_addr(miss_addr), .miss_is_store(miss_is_store),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic expect_pf(input logic [31:0] line, input string tag);
        exp_q.push_back(line << 7);
        tag_q.push_back(tag);
    endtask

    task automatic miss(input logic [31:0] addr, input bit st);
        @(negedge clk);
        while (!miss_ready) @(negedge clk);
        miss_valid = 1'b1;
        miss_addr = addr;
        miss_is_store = st;
        @(negedge clk);
        miss_valid = 1'b0;
        miss_is_store = 1'b0;
    endtask

    task automatic load_line(input logic [31:0] line);
        miss(line << 7, 1'b0);
    endtask

    task automatic drain(input string tag);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0 && !pf_valid, tag, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        tag_q.delete();
    endtask

    // monitor: scoreboard pop on every handshake
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && pf_valid && pf_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected request", pf_addr, 32'hx);
                end else begin
                    logic [31:0] w;
                    string t;
                    w = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(pf_addr == w, t, pf_addr, w);
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!pf_valid, "R1 pf_valid", 32'(pf_valid), 0);
        check(miss_ready, "R1 miss_ready", 32'(miss_ready), 1);
        rst_n = 1'b1;

        // R3 R4 ascending run
        load_line(32'h20);
        expect_pf(32'h22, "R3 asc first"); expect_pf(32'h23, "R3 asc second");
        load_line(32'h21);
        expect_pf(32'h24, "R4 asc advance");
        load_line(32'h22);
        expect_pf(32'h25, "R4 asc advance2");
        load_line(32'h23);
        drain("R4 asc drained");

        // R2 descending guess from offset 100
        miss((32'h200 << 7) + 100, 1'b0);
        expect_pf(32'h1FE, "R2 desc first"); expect_pf(32'h1FD, "R2 desc second");
        load_line(32'h1FF);
        expect_pf(32'h1FC, "R4 desc advance");
        load_line(32'h1FE);
        drain("R2 desc drained");

        // R2 boundaries 95 and 96
        miss((32'h300 << 7) + 95, 1'b0);
        expect_pf(32'h302, "R2 off95 asc"); expect_pf(32'h303, "R2 off95 asc2");
        load_line(32'h301);
        miss((32'h400 << 7) + 96, 1'b0);
        expect_pf(32'h3FE, "R2 off96 desc"); expect_pf(32'h3FD, "R2 off96 desc2");
        load_line(32'h3FF);
        drain("R2 boundary drained");

        // R5 store ignored, R6 stream priority (stream next is 0x24)
        miss(32'h500 << 7, 1'b1);
        load_line(32'h501);
        drain("R5 store no train");
        miss(32'h24 << 7, 1'b1);
        load_line(32'h23);
        expect_pf(32'h26, "R5 R6 single advance");
        load_line(32'h24);
        drain("R6 drained");

        // R7 filter FIFO replacement
        for (int k = 0; k < 13; k++) load_line(32'h1000 + 4 * k);
        load_line(32'h1001);
        drain("R7 oldest evicted");
        expect_pf(32'h100A, "R7 kept entry"); expect_pf(32'h100B, "R7 kept entry2");
        load_line(32'h1009);
        expect_pf(32'h1032, "R7 newest entry"); expect_pf(32'h1033, "R7 newest entry2");
        load_line(32'h1031);
        drain("R7 drained");

        // R8 LRU stream replacement
        for (int k = 0; k < 8; k++) begin
            load_line(32'h2000 + 16 * k);
            expect_pf(32'h2002 + 16 * k, "R8 build");
            expect_pf(32'h2003 + 16 * k, "R8 build2");
            load_line(32'h2001 + 16 * k);
        end
        expect_pf(32'h2004, "R8 touch oldest");
        load_line(32'h2002);
        load_line(32'h2080);
        expect_pf(32'h2082, "R8 new stream"); expect_pf(32'h2083, "R8 new stream2");
        load_line(32'h2081);
        drain("R8 built");
        load_line(32'h2012);
        drain("R8 lru evicted");
        expect_pf(32'h2024, "R8 survivor");
        load_line(32'h2022);
        drain("R8 drained");

        // R9 R10 backpressure
        pf_ready = 1'b0;
        expect_pf(32'h2025, "R9 order first");
        load_line(32'h2023);
        expect_pf(32'h2034, "R9 order second");
        load_line(32'h2032);
        expect_pf(32'h2044, "R9 order third");
        load_line(32'h2042);
        @(negedge clk);
        check(!miss_ready, "R10 miss_ready low", 32'(miss_ready), 0);
        check(pf_valid && pf_addr == (32'h2025 << 7), "R9 held", pf_addr, 32'h2025 << 7);
        repeat (3) @(negedge clk);
        check(pf_addr == (32'h2025 << 7), "R9 stable", pf_addr, 32'h2025 << 7);
        pf_ready = 1'b1;
        drain("R9 drained");
        check(miss_ready, "R10 miss_ready back", 32'(miss_ready), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule